// File: doc/BRIEF.md
# I2C Bus Stall Watchdog

This block guards an I2C controller against a bus that stops making progress. While the controller and the watchdog are both enabled, a counter advances on every peripheral clock, or on every fourth one when the slow rate is selected. Each controller event pulse restarts the count. The count therefore measures only the idle gap since the last event. When the counter passes its top value, it wraps to zero and sets a sticky time-out flag. That flag is the interrupt request to the controller's interrupt logic.

Software clears the flag by writing a one to its bit. A write of zero leaves the flag alone. The counter width and the slow-rate divisor are parameters. The default is a 14-bit count and a divide-by-4 slow rate. Turning either enable off returns the counter and the prescaler to zero. The flag keeps its value when the enables are turned off.

Top module: `i2c_tmo_watch`

## Requirements
- R1: After reset, `to_flag` and `irq` are 0.
- R2: With `ctl_en` and `to_en` both high, `div_sel` low and `evt_si` low, `to_flag` first reads 1 after exactly 2^CNT_W rising clock edges counted from the first edge with both enables high (16384 by default).
- R3: With `div_sel` high, the count advances on every 2^DIV_EXP-th enabled edge, starting with the 2^DIV_EXP-th one. The prescaler runs freely while enabled, so `to_flag` sets after 2^DIV_EXP * 2^CNT_W enabled edges.
- R4: An edge with `evt_si` high clears the counter but not the prescaler. `to_flag` then sets on the 2^CNT_W-th count advance after that edge. While `evt_si` stays high, `to_flag` never sets.
- R5: An edge with `ctl_en` or `to_en` low resets both the counter and the prescaler. When the enables return, timing starts afresh as in R2 and R3.
- R6: On overflow the counter wraps to zero and keeps counting. The next overflow comes 2^CNT_W count advances later.
- R7: `to_flag` is sticky. It stays at 1 when the enables drop or when `evt_si` pulses.
- R8: An edge with `wr_en` high and `wr_data` = 1 clears `to_flag`. A write with `wr_data` = 0, or `wr_data` = 1 without `wr_en`, leaves it unchanged.
- R9: When an overflow and a clearing write fall on the same edge, `to_flag` is 1 afterwards.
- R10: `irq` always equals `to_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_en | input | 1 | I2C controller enable |
| to_en | input | 1 | Time-out watchdog enable |
| div_sel | input | 1 | 1: count once every 2^DIV_EXP clocks; 0: count every clock |
| evt_si | input | 1 | Controller event pulse; restarts the count |
| wr_en | input | 1 | Register write strobe for the flag bit |
| wr_data | input | 1 | Value written to the flag bit (1 clears) |
| to_flag | output | 1 | Sticky time-out flag |
| irq | output | 1 | Interrupt request, equal to the flag |

## Verification
The assertions check on every cycle that:
- the counter is zero after any edge with an enable low or with an event pulse;
- the counter moves by at most one step per edge, and by exactly one step at the full rate;
- the flag rises only on a wrap from the top value while enabled;
- the flag falls only after a clearing write.

Only the bench scenarios can show the absolute distances to a time-out. These are the full-rate and slow-rate periods, the prescaler phase left over after an event pulse, the restart after an enable drops, the second wrap, and the set-over-clear priority. The bench sweeps the event position over a reduced counter width and computes each expected distance arithmetically.

// File: rtl/i2c_tmo_pkg.sv
package i2c_tmo_pkg;
   localparam int unsigned DEF_CNT_W   = 14;
   localparam int unsigned DEF_DIV_EXP = 2;

   // count advance period in clocks for a given rate select
   function automatic int unsigned adv_period(input int unsigned div_exp, input logic slow);
      return slow ? (32'd1 << div_exp) : 32'd1;
   endfunction
endpackage

// File: rtl/i2c_tmo_prescale.sv
module i2c_tmo_prescale #(
   parameter int unsigned DIV_EXP = i2c_tmo_pkg::DEF_DIV_EXP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic div_sel,
   output logic adv
);
   generate
      if (DIV_EXP == 0) begin : g_nodiv
         assign adv = run & (div_sel | 1'b1);
      end else begin : g_div
         logic [DIV_EXP-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   pre_q <= '0;
            else if (!run) pre_q <= '0;
            else           pre_q <= pre_q + 1'b1;
         end
         assign adv = run & (div_sel ? (&pre_q) : 1'b1);
      end
   endgenerate
endmodule

// File: rtl/i2c_tmo_count.sv
module i2c_tmo_count #(
   parameter int unsigned CNT_W = i2c_tmo_pkg::DEF_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             adv,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run || restart) cnt_q <= '0;
      else if (adv)              cnt_q <= cnt_q + 1'b1;
   end

   assign wrap = run & ~restart & adv & (cnt_q == TOP);
endmodule

// File: rtl/i2c_tmo_flag.sv
module i2c_tmo_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    flag_q <= 1'b0;
      else if (set)  flag_q <= 1'b1;
      else if (clr)  flag_q <= 1'b0;
   end
endmodule

// File: rtl/i2c_tmo_watch.sv
module i2c_tmo_watch #(
   parameter int unsigned CNT_W   = i2c_tmo_pkg::DEF_CNT_W,
   parameter int unsigned DIV_EXP = i2c_tmo_pkg::DEF_DIV_EXP
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_en,
   input  logic to_en,
   input  logic div_sel,
   input  logic evt_si,
   input  logic wr_en,
   input  logic wr_data,
   output logic to_flag,
   output logic irq
);
   initial begin : cfg_chk
      assert (CNT_W >= 2 && CNT_W <= 31) else $fatal(1, "CNT_W out of range");
      assert (DIV_EXP <= 8) else $fatal(1, "DIV_EXP out of range");
   end

   logic             run;
   logic             adv;
   logic             wrap;
   logic [CNT_W-1:0] cnt_q;

   assign run = ctl_en & to_en;

   i2c_tmo_prescale #(.DIV_EXP(DIV_EXP)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .adv(adv)
   );

   i2c_tmo_count #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run(run), .restart(evt_si),
      .adv(adv), .cnt_q(cnt_q), .wrap(wrap)
   );

   i2c_tmo_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(wrap), .clr(wr_en & wr_data), .flag_q(to_flag)
   );

   assign irq = to_flag;
endmodule

// File: rtl/i2c_tmo_watch_chk.sv
module i2c_tmo_watch_chk #(
   parameter int unsigned CNT_W = 14
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctl_en,
   input logic             to_en,
   input logic             div_sel,
   input logic             evt_si,
   input logic             wr_en,
   input logic             wr_data,
   input logic             to_flag,
   input logic [CNT_W-1:0] cnt_q
);
   // R4
   si_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_si |=> cnt_q == '0);

   // R5
   off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctl_en && to_en) |=> cnt_q == '0);

   // R3
   step_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && to_en && !evt_si) |=>
         (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   // R2
   full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_en && to_en && !evt_si && !div_sel) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   // R6
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0
                          && $past(ctl_en && to_en && !evt_si)));

   // R8
   flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(to_flag) |-> $past(wr_en && wr_data));
endmodule

bind i2c_tmo_watch i2c_tmo_watch_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .to_en(to_en), .div_sel(div_sel),
   .evt_si(evt_si), .wr_en(wr_en), .wr_data(wr_data), .to_flag(to_flag), .cnt_q(cnt_q)
);

// File: tb/i2c_tmo_watch_tb.sv
`timescale 1ns/1ps
module i2c_tmo_watch_tb;
   localparam int W    = 6;
   localparam int DE   = 2;
   localparam int FULL = 1 << W;
   localparam int DIVN = 1 << DE;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ctl_en = 1'b0, to_en = 1'b0, div_sel = 1'b0, evt_si = 1'b0;
   logic wr_en = 1'b0, wr_data = 1'b0;
   logic to_flag, irq;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #2.5 clk = ~clk;

   i2c_tmo_watch #(.CNT_W(W), .DIV_EXP(DE)) u_dut (
      .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en), .to_en(to_en), .div_sel(div_sel),
      .evt_si(evt_si), .wr_en(wr_en), .wr_data(wr_data), .to_flag(to_flag), .irq(irq)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // disable, clear flag, leave at a negedge with enables low
   task automatic idle();
      ctl_en = 1'b0; to_en = 1'b0; evt_si = 1'b0; wr_en = 1'b1; wr_data = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 1'b0;
   endtask

   // counts negedges until the flag reads 1
   task automatic measure(output int n);
      n = 0;
      while (!to_flag && n < 2000) begin
         @(negedge clk);
         n++;
      end
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      int n;
      repeat (3) @(negedge clk);
      chk("R1 flag", int'(to_flag), 0);
      chk("R1 irq", int'(irq), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R3 base periods
      for (int d = 0; d < 2; d++) begin
         idle();
         div_sel = d[0]; ctl_en = 1'b1; to_en = 1'b1;
         measure(n);
         chk(d ? "R3 slow period" : "R2 full period", n, d ? DIVN * FULL : FULL);
         chk("R10 irq", int'(irq), 1);
      end

      // R4 sweep of event position against prescaler phase
      for (int d = 0; d < 2; d++) begin
         for (int k = 0; k < 12; k++) begin
            int e, s, exp;
            idle();
            div_sel = d[0]; ctl_en = 1'b1; to_en = 1'b1;
            repeat (k) @(negedge clk);
            evt_si = 1'b1;
            @(negedge clk);
            evt_si = 1'b0;
            e = k + 1;
            if (d == 0) exp = FULL;
            else begin
               s = (e / DIVN + 1) * DIVN;
               exp = s + DIVN * (FULL - 1) - e;
            end
            measure(n);
            chk("R4 restart after event", n, exp);
         end
      end

      // R4 held event never times out
      idle();
      div_sel = 1'b0; ctl_en = 1'b1; to_en = 1'b1; evt_si = 1'b1;
      repeat (3 * FULL) @(negedge clk);
      chk("R4 held event", int'(to_flag), 0);
      evt_si = 1'b0;

      // R5 drop each enable mid-count
      for (int w = 0; w < 2; w++) begin
         idle();
         div_sel = 1'b1; ctl_en = 1'b1; to_en = 1'b1;
         repeat (DIVN * FULL - 3) @(negedge clk);
         if (w == 0) to_en = 1'b0; else ctl_en = 1'b0;
         @(negedge clk);
         to_en = 1'b1; ctl_en = 1'b1;
         measure(n);
         chk("R5 restart after disable", n, DIVN * FULL);
      end

      // R6 wrap and second overflow, R8 clear
      idle();
      div_sel = 1'b0; ctl_en = 1'b1; to_en = 1'b1;
      measure(n);
      chk("R6 first overflow", n, FULL);
      wr_en = 1'b1; wr_data = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 1'b0;
      chk("R8 write one clears", int'(to_flag), 0);
      measure(n);
      chk("R6 second overflow", n, FULL - 1);

      // R7 sticky across disable and event
      ctl_en = 1'b0; to_en = 1'b0; evt_si = 1'b1;
      repeat (5) @(negedge clk);
      evt_si = 1'b0;
      chk("R7 sticky", int'(to_flag), 1);

      // R8 ignored writes
      wr_en = 1'b1; wr_data = 1'b0;
      @(negedge clk);
      chk("R8 write zero ignored", int'(to_flag), 1);
      wr_en = 1'b0; wr_data = 1'b1;
      @(negedge clk);
      chk("R8 data without strobe ignored", int'(to_flag), 1);
      wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 1'b0;
      chk("R8 write one clears", int'(to_flag), 0);
      chk("R10 irq low", int'(irq), 0);

      // R9 set beats clear on the same edge
      idle();
      div_sel = 1'b0; ctl_en = 1'b1; to_en = 1'b1;
      repeat (FULL - 1) @(negedge clk);
      chk("R9 before wrap", int'(to_flag), 0);
      wr_en = 1'b1; wr_data = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 1'b0;
      chk("R9 set wins", int'(to_flag), 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule